// File: doc/BRIEF.md
# Barrel Shifter Operand Stage with Carry-Out

This unit forms the second operand for a 32-bit data-processing instruction together with the carry that the shifter produces. It takes the instruction word, the value of the shifted source register, the value of the register that supplies a shift amount, and the current carry flag. It returns the operand and the shifter carry. It does not read a register file and does not update any flag. The surrounding pipeline decides whether the carry is committed.

Two source forms are supported. The first is an 8-bit immediate rotated by an even amount. The second is a register value shifted left, shifted right logically, shifted right arithmetically, or rotated right. In the register form the amount comes either from a 5-bit immediate field or from the low byte of a second register. The zero, 32 and over-32 amounts follow exact rules: a zero immediate amount stands for 32 or for rotate-through-carry, depending on the shift type.

An optional output register, selected by a parameter and enabled by default, lets the unit sit on a pipeline boundary.

Top module: `shifter_operand_unit`

## Requirements
- R1: With `REG_OUT`=1, `operand` and `carryOut` are 0 while `rstN` is low. After that, each result appears one clock after its inputs.
- R2: When `instr[25]` is 1, the operand is `instr[7:0]` rotated right by 2×`instr[11:8]`. The carry is `carryIn` when `instr[11:8]` is 0 and bit 31 of the operand otherwise.
- R3: When `instr[25]` is 0, `instr[6:5]` selects the shift type (0 = left, 1 = logical right, 2 = arithmetic right, 3 = rotate right). `instr[4]` = 0 takes the amount from `instr[11:7]`; `instr[4]` = 1 takes it from `rsVal[7:0]`.
- R4: A left shift by an immediate of 0 passes `rmVal` through unchanged, with the carry equal to `carryIn`.
- R5: A logical right shift by an immediate of 0 acts as a shift by 32: the result is 0 and the carry is `rmVal[31]`.
- R6: An arithmetic right shift by an immediate of 0 acts as a shift by 32: every result bit equals `rmVal[31]`, and so does the carry.
- R7: A rotate by an immediate of 0 rotates through the carry: the result is {`carryIn`, `rmVal[31:1]`} and the carry is `rmVal[0]`.
- R8: For a register amount, only `rsVal[7:0]` is used. If that byte is 0, the result is `rmVal` unchanged and the carry is `carryIn`, whatever the upper bits of `rsVal` hold.
- R9: For a register left or logical right shift: an amount of exactly 32 gives a result of 0, with carry `rmVal[0]` for a left shift and `rmVal[31]` for a right shift. An amount above 32 gives a result of 0 and a carry of 0.
- R10: For a register arithmetic right shift of 32 or more, every result bit and the carry equal `rmVal[31]`.
- R11: For a register rotate with a nonzero amount, the rotation is by the low 5 bits of the amount and the carry is the last bit rotated out. When those 5 bits are 0, the result is `rmVal` and the carry is `rmVal[31]`.
- R12: For an amount n with 1 ≤ n ≤ 31, a left shift yields carry `rmVal[32-n]` and a right shift (logical or arithmetic) yields carry `rmVal[n-1]`. This holds for both the immediate and the register amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset of the output register |
| instr | input | 32 | Instruction word; only the shift fields are decoded |
| rmVal | input | 32 | Value of the register being shifted |
| rsVal | input | 32 | Value of the register supplying a shift amount |
| carryIn | input | 1 | Current carry flag |
| operand | output | 32 | Shifted or rotated second operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The bench sweeps all eight register shift encodings with amounts 0, 1, 31, 32, 33 and 255. It uses source values whose end bits differ, so a carry taken from the wrong bit position shows up at once. A design that treated a zero immediate amount literally would pass the value through where zero, a sign fill or a rotate through carry is due. A design that masked the register amount to five bits would shift by 1 instead of 33 and by 31 instead of 255. A design that skipped the exact-32 case would lose the `rmVal[0]` or `rmVal[31]` carry. The immediate rotate is checked at rotate 0, where the old carry must survive, and at nonzero rotates, where the carry must follow bit 31.

// File: rtl/shop_pkg.sv
`timescale 1ns/1ps
package shop_pkg;

  localparam int DATA_W   = 32;
  localparam int INSTR_W  = 32;
  localparam int AMT_W    = 8;
  localparam int IMM_W    = 8;
  localparam int ROT_W    = 4;
  localparam int SHIMM_W  = 5;
  localparam int CAP_W    = $clog2(DATA_W + 2);

  // Field positions in the instruction word that the decode depends on
  localparam int IMM_FORM_BIT = 25;
  localparam int ROT_LSB      = 8;
  localparam int SHIMM_LSB    = 7;
  localparam int KIND_LSB     = 5;
  localparam int BYREG_BIT    = 4;

  typedef enum logic [2:0] {
    MODE_PASS = 3'd0,
    MODE_LSL  = 3'd1,
    MODE_LSR  = 3'd2,
    MODE_ASR  = 3'd3,
    MODE_ROR  = 3'd4,
    MODE_RRX  = 3'd5
  } shop_mode_e;

  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } shop_kind_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic             useImm;
    shop_mode_e       mode;
    logic [AMT_W-1:0] amt;
  } shop_ctrl_t;

endpackage

// File: rtl/shop_ctrl.sv
`timescale 1ns/1ps
module shop_ctrl
  import shop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [AMT_W-1:0]   rsLow,
  output shop_ctrl_t         ctrl
);

  logic [ROT_W-1:0]   rotField;
  logic [SHIMM_W-1:0] shImm;
  shop_kind_e         kind;
  logic               byReg;

  assign rotField = instr[ROT_LSB +: ROT_W];
  assign shImm    = instr[SHIMM_LSB +: SHIMM_W];
  assign kind     = shop_kind_e'(instr[KIND_LSB +: 2]);
  assign byReg    = instr[BYREG_BIT];

  function automatic shop_mode_e kindToMode(input shop_kind_e k);
    case (k)
      KIND_LSL: kindToMode = MODE_LSL;
      KIND_LSR: kindToMode = MODE_LSR;
      KIND_ASR: kindToMode = MODE_ASR;
      default:  kindToMode = MODE_ROR;
    endcase
  endfunction

  always_comb begin
    ctrl.useImm = instr[IMM_FORM_BIT];
    ctrl.mode   = MODE_PASS;
    ctrl.amt    = '0;
    if (instr[IMM_FORM_BIT]) begin
      // Even rotate of the 8-bit literal
      ctrl.amt  = AMT_W'({rotField, 1'b0});
      ctrl.mode = (rotField == '0) ? MODE_PASS : MODE_ROR;
    end else if (byReg) begin
      ctrl.amt  = rsLow;
      ctrl.mode = (rsLow == '0) ? MODE_PASS : kindToMode(kind);
    end else if (shImm == '0) begin
      // Zero immediate amount: per-type meaning
      case (kind)
        KIND_LSL: ctrl.mode = MODE_PASS;
        KIND_LSR: begin ctrl.mode = MODE_LSR; ctrl.amt = AMT_W'(DATA_W); end
        KIND_ASR: begin ctrl.mode = MODE_ASR; ctrl.amt = AMT_W'(DATA_W); end
        default:  ctrl.mode = MODE_RRX;
      endcase
    end else begin
      ctrl.amt  = AMT_W'(shImm);
      ctrl.mode = kindToMode(kind);
    end
  end

endmodule

// File: rtl/shop_datapath.sv
`timescale 1ns/1ps
module shop_datapath
  import shop_pkg::*;
(
  input  shop_ctrl_t          ctrl,
  input  logic [DATA_W-1:0]   rmVal,
  input  logic [IMM_W-1:0]    immByte,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   result,
  output logic                carry
);

  localparam int ROT_AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]     src;
  logic [CAP_W-1:0]      capWide;   // clamp to DATA_W+1
  logic [CAP_W-1:0]      capSign;   // clamp to DATA_W
  logic [DATA_W:0]       lslExt;
  logic [DATA_W:0]       lsrExt;
  logic signed [DATA_W:0] asrExt;
  logic [ROT_AMT_W-1:0]  rotAmt;
  logic [DATA_W-1:0]     rorRes;

  assign src = ctrl.useImm ? DATA_W'(immByte) : rmVal;

  assign capWide = (ctrl.amt > AMT_W'(DATA_W + 1)) ? CAP_W'(DATA_W + 1) : CAP_W'(ctrl.amt);
  assign capSign = (ctrl.amt > AMT_W'(DATA_W))     ? CAP_W'(DATA_W)     : CAP_W'(ctrl.amt);

  // Extended shifts: the extra bit catches the last bit shifted out
  assign lslExt = {1'b0, src} << capWide;
  assign lsrExt = {src, 1'b0} >> capWide;
  assign asrExt = $signed({src, 1'b0}) >>> capSign;

  assign rotAmt = ctrl.amt[ROT_AMT_W-1:0];
  assign rorRes = (rotAmt == '0) ? src
                : ((src >> rotAmt) | (src << (ROT_AMT_W'(DATA_W - 1) - rotAmt + 1'b1)));

  always_comb begin
    result = src;
    carry  = carryIn;
    case (ctrl.mode)
      MODE_LSL: begin result = lslExt[DATA_W-1:0]; carry = lslExt[DATA_W]; end
      MODE_LSR: begin result = lsrExt[DATA_W:1];   carry = lsrExt[0];      end
      MODE_ASR: begin result = asrExt[DATA_W:1];   carry = asrExt[0];      end
      MODE_ROR: begin result = rorRes;             carry = rorRes[DATA_W-1]; end
      MODE_RRX: begin result = {carryIn, src[DATA_W-1:1]}; carry = src[0]; end
      default:  begin result = src;                carry = carryIn;        end
    endcase
  end

endmodule

// File: rtl/shop_outreg.sv
`timescale 1ns/1ps
module shop_outreg
  import shop_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  logic              cIn,
  output logic [DATA_W-1:0] dOut,
  output logic              cOut
);

  generate
    if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] dQ;
      logic              cQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dQ <= '0;
          cQ <= 1'b0;
        end else begin
          dQ <= dIn;
          cQ <= cIn;
        end
      end
      assign dOut = dQ;
      assign cOut = cQ;
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
      assign dOut = dIn;
      assign cOut = cIn;
    end
  endgenerate

endmodule

// File: rtl/shifter_operand_unit.sv
`timescale 1ns/1ps
module shifter_operand_unit
  import shop_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instr,
  input  logic [31:0] rmVal,
  input  logic [31:0] rsVal,
  input  logic        carryIn,
  output logic [31:0] operand,
  output logic        carryOut
);

  shop_ctrl_t        ctrl;
  logic [DATA_W-1:0] dpResult;
  logic              dpCarry;
  logic [DATA_W-AMT_W-1:0] rsHighUnused;

  assign rsHighUnused = rsVal[DATA_W-1:AMT_W];

  shop_ctrl i_ctrl (
    .instr (instr),
    .rsLow (rsVal[AMT_W-1:0]),
    .ctrl  (ctrl)
  );

  shop_datapath i_dp (
    .ctrl    (ctrl),
    .rmVal   (rmVal),
    .immByte (instr[IMM_W-1:0]),
    .carryIn (carryIn),
    .result  (dpResult),
    .carry   (dpCarry)
  );

  shop_outreg #(.REG_OUT(REG_OUT)) i_out (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (dpResult),
    .cIn  (dpCarry),
    .dOut (operand),
    .cOut (carryOut)
  );

endmodule

// File: rtl/shop_checker.sv
`timescale 1ns/1ps
module shop_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] instr,
  input logic [31:0] rmVal,
  input logic [31:0] rsVal,
  input logic        carryIn,
  input logic [31:0] operand,
  input logic        carryOut
);

  logic regForm;
  logic [1:0] kindF;
  assign regForm = !instr[25];
  assign kindF   = instr[6:5];

  generate
    if (REG_OUT) begin : g_chk
      // R2: nonzero rotate carry follows bit 31 of the result
      a_r2_rot_carry: assert property (@(posedge clk) disable iff (!rstN)
        (instr[25] && instr[11:8] != 4'd0) |=> (carryOut == operand[31]));

      // R4: left shift by immediate zero is a pass-through
      a_r4_lsl_zero: assert property (@(posedge clk) disable iff (!rstN)
        (regForm && instr[6:4] == 3'd0 && instr[11:7] == 5'd0)
        |=> (operand == $past(rmVal) && carryOut == $past(carryIn)));

      // R5: logical right by immediate zero means by 32
      a_r5_lsr_imm32: assert property (@(posedge clk) disable iff (!rstN)
        (regForm && instr[6:4] == 3'd2 && instr[11:7] == 5'd0)
        |=> (operand == 32'd0 && carryOut == $past(rmVal[31])));

      // R7: rotate by immediate zero rotates through carry
      a_r7_rrx: assert property (@(posedge clk) disable iff (!rstN)
        (regForm && instr[6:4] == 3'd6 && instr[11:7] == 5'd0)
        |=> (operand == {$past(carryIn), $past(rmVal[31:1])} && carryOut == $past(rmVal[0])));

      // R8: zero register amount leaves operand and carry untouched
      a_r8_reg_zero: assert property (@(posedge clk) disable iff (!rstN)
        (regForm && instr[4] && rsVal[7:0] == 8'd0)
        |=> (operand == $past(rmVal) && carryOut == $past(carryIn)));

      // R9: register left/logical-right above 32 clears result and carry
      a_r9_over32: assert property (@(posedge clk) disable iff (!rstN)
        (regForm && instr[4] && !kindF[1] && rsVal[7:0] > 8'd32)
        |=> (operand == 32'd0 && !carryOut));

      // R10: register arithmetic right of 32 or more fills with the sign
      a_r10_asr_fill: assert property (@(posedge clk) disable iff (!rstN)
        (regForm && instr[6:4] == 3'd5 && rsVal[7:0] >= 8'd32)
        |=> (operand == {32{$past(rmVal[31])}} && carryOut == $past(rmVal[31])));

      // R11: register rotate with zero low five bits keeps the value
      a_r11_ror_wrap: assert property (@(posedge clk) disable iff (!rstN)
        (regForm && instr[6:4] == 3'd7 && rsVal[7:0] != 8'd0 && rsVal[4:0] == 5'd0)
        |=> (operand == $past(rmVal) && carryOut == $past(rmVal[31])));
    end
  endgenerate

endmodule

bind shifter_operand_unit shop_checker #(.REG_OUT(REG_OUT)) i_shop_checker (
  .clk      (clk),
  .rstN     (rstN),
  .instr    (instr),
  .rmVal    (rmVal),
  .rsVal    (rsVal),
  .carryIn  (carryIn),
  .operand  (operand),
  .carryOut (carryOut)
);

// File: tb/test_shifter_operand_unit.sv
`timescale 1ns/1ps
module test_shifter_operand_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rmVal = '0;
  logic [31:0] rsVal = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operand;
  logic        carryOut;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        c;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #2.5 clk = ~clk;   // 200 MHz

  shifter_operand_unit #(.REG_OUT(1'b1)) i_shifter_operand_unit (
    .clk(clk), .rstN(rstN), .instr(instr), .rmVal(rmVal), .rsVal(rsVal),
    .carryIn(carryIn), .operand(operand), .carryOut(carryOut)
  );

  // Behavioural reference: bit-serial stepping, one position per step
  function automatic exp_t refModel(input logic [31:0] ir, input logic [31:0] rm,
                                    input logic [31:0] rs, input logic cin);
    exp_t e;
    logic [31:0] v;
    logic c;
    int n;
    logic [1:0] k;
    c = cin;
    k = ir[6:5];
    if (ir[25]) begin
      v = {24'd0, ir[7:0]};
      n = 2 * int'(ir[11:8]);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      if (n != 0) c = v[31];
      e.tag = "R2";
    end else begin
      v = rm;
      n = ir[4] ? int'(rs[7:0]) : int'(ir[11:7]);
      if (!ir[4] && n == 0) begin
        case (k)
          2'd0: e.tag = "R4";
          2'd1: begin n = 32; e.tag = "R5"; end
          2'd2: begin n = 32; e.tag = "R6"; end
          default: e.tag = "R7";
        endcase
        if (k == 2'd3) begin
          c = v[0];
          v = {cin, v[31:1]};
          n = 0;
        end
      end else if (n == 0) e.tag = "R8";
      else if (n == 32 || n > 32) e.tag = (k == 2'd3) ? "R11" : ((k == 2'd2) ? "R10" : "R9");
      else e.tag = (k == 2'd3) ? "R11" : "R12";
      for (int i = 0; i < n; i++) begin
        case (k)
          2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
          2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
          2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
          default: begin c = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
    e.res = v;
    e.c = c;
    return e;
  endfunction

  task automatic drive(input logic [31:0] ir, input logic [31:0] rm,
                       input logic [31:0] rs, input logic cin);
    @(negedge clk);
    instr = ir; rmVal = rm; rsVal = rs; carryIn = cin;
    expQ.push_back(refModel(ir, rm, rs, cin));
  endtask

  // Monitor: one result per clock, one cycle behind its inputs (R1)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (running && expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (operand !== e.res || carryOut !== e.c) begin
          errors++;
          $display("FAIL %s: instr=%h got op=%h c=%b expected op=%h c=%b",
                   e.tag, instr, operand, carryOut, e.res, e.c);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rmSet [3];
    int regAmts [6];
    int immAmts [5];
    rmSet[0] = 32'h8000_0001; rmSet[1] = 32'h7FFF_FFFE; rmSet[2] = 32'hA5C3_0F96;
    regAmts[0] = 0; regAmts[1] = 1; regAmts[2] = 31; regAmts[3] = 32;
    regAmts[4] = 33; regAmts[5] = 255;
    immAmts[0] = 0; immAmts[1] = 1; immAmts[2] = 31; immAmts[3] = 16; immAmts[4] = 7;

    instr = 32'h0000_0060; rmVal = 32'hFFFF_FFFF; carryIn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: held in reset, outputs are zero
    checks++;
    if (operand !== 32'd0 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R1: got op=%h c=%b expected op=0 c=0", operand, carryOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;

    // R3, R4..R7, R12: immediate-amount forms
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 5; a++)
        for (int r = 0; r < 3; r++)
          for (int ci = 0; ci < 2; ci++)
            drive({7'd0, 1'b0, 12'd0, 4'd0, immAmts[a][4:0], t[1:0], 1'b0, 4'd0},
                  rmSet[r], 32'h0, ci[0]);

    // R3, R8..R12: register-amount forms; upper rs bits set to show they are ignored
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 6; a++)
        for (int r = 0; r < 3; r++)
          for (int ci = 0; ci < 2; ci++)
            drive({7'd0, 1'b0, 12'd0, 4'd0, 1'b0, t[1:0], 1'b1, 4'd0},
                  rmSet[r], {24'hDEAD_C0, regAmts[a][7:0]}, ci[0]);

    // R11: register rotate by 64 and by 40
    drive(32'h0000_0070, 32'h8000_0001, 32'h0000_0040, 1'b0);
    drive(32'h0000_0070, 32'h1234_5679, 32'h0000_0028, 1'b1);

    // R2: immediate rotate, zero and nonzero rotates
    for (int rot = 0; rot < 16; rot += 3)
      for (int ci = 0; ci < 2; ci++)
        drive({6'd0, 1'b1, 13'd0, rot[3:0], 8'hC3}, 32'hFFFF_FFFF, 32'h0, ci[0]);
    drive({6'd0, 1'b1, 13'd0, 4'd1, 8'h01}, 32'h0, 32'h0, 1'b0);
    drive({6'd0, 1'b1, 13'd0, 4'd4, 8'h80}, 32'h0, 32'h0, 1'b1);

    @(negedge clk);
    wait (expQ.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule